// File: doc/BRIEF.md
# Adaptive Dead-Time Gate Controller

This block sequences the two gate enables of a synchronous half-bridge from a single PWM input. The high-side enable follows the PWM level and the low-side enable follows its inverse. Between the two conduction intervals the block inserts a dead time, and that dead time depends on what the power stage reports. When the high side hands over to the low side, the block watches the switch node: first it must rise above its upper threshold, then fall below roughly 1 V. If the node never rose, a fixed delay is used instead. If the node rose but never came back down, a timeout ends the wait. When the low side hands over to the high side, the block waits for a flag saying that the low-side gate has dropped below one sixth of the supply, then adds a short fixed delay.

All asynchronous flags pass through a synchronizer before the sequencer uses them. An active-low disable input cuts both enables combinationally in the same cycle, and it also returns the sequencer to its idle state. An undervoltage flag holds the sequencer idle with both enables off. Every delay is a parameter counted in clock cycles. The defaults suit a 100 MHz clock: 15, 19 and 3 cycles. A state output lets a bench observe the sequence.

Top module: `gate_seq_ctrl`

## Requirements
- R1: In steady state with enables active, `hs_en_o` is 1 and `ls_en_o` is 0 while PWM is high, and `hs_en_o` is 0 and `ls_en_o` is 1 while PWM is low.
- R2: `hs_en_o` and `ls_en_o` are never 1 in the same cycle.
- R3: While `dis_n_i` is 0, both enables are 0 in that same cycle without waiting for a clock edge. Once the low level has passed the synchronizer, the state is idle. After release, normal sequencing restarts from idle.
- R4: If the switch node has been seen high after the high-side turn-off, the low-side enable turns on 3 cycles after `sw_lo_i` is driven high. This is two synchronizer stages plus one state update.
- R5: If the switch node was never seen high, the low-side enable turns on exactly FIXED_DLY cycles after the high-side enable turns off.
- R6: If the switch node was seen high but `sw_lo_i` never asserts, the low-side enable turns on exactly TIMEOUT cycles after the high-side enable turns off. The wait never lasts longer than that.
- R7: The high-side enable stays off while `gfb_lo_i` is 0. It turns on HS_DLY+3 cycles after `gfb_lo_i` goes high while the block is waiting for it.
- R8: While `uvlo_i` is 1, both enables are 0 and the state is idle. The enables fall 3 cycles after `uvlo_i` rises. After `uvlo_i` clears, sequencing restarts from idle.
- R9: If PWM reverses during a dead-time wait, the wait is abandoned. The opposite transition starts from a both-off state, and the enable that was being waited for never turns on.
- R10: A PWM edge reaches the turn-off of the conducting enable 3 cycles after it is applied.
- R11: `state_o` encodes idle=0, waiting to turn on the low side=1, low side on=2, waiting for low-gate feedback=3, high-side delay=4, high side on=5. Reset leaves it at 0 with both enables off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| pwm_i | input | 1 | PWM command (asynchronous) |
| dis_n_i | input | 1 | Active-low output disable |
| uvlo_i | input | 1 | Undervoltage lockout flag, active high |
| sw_hi_i | input | 1 | Switch node above its upper threshold |
| sw_lo_i | input | 1 | Switch node below about 1 V |
| gfb_lo_i | input | 1 | Low-side gate below one sixth of the supply |
| hs_en_o | output | 1 | High-side gate enable |
| ls_en_o | output | 1 | Low-side gate enable |
| state_o | output | 3 | Sequencer state code (see R11) |

## Verification
The assertions check four things on every cycle: that the enables never overlap, that the disable input cuts both enables at once, that each enable turns on only from its own wait state, and that a low-side wait never exceeds the timeout. They also check that a held disable or undervoltage flag parks the sequencer in idle. The exact cycle counts of the three low-side paths (adaptive, fixed fallback and timeout) and the gate-feedback delay before the high side turns on can only be shown by the bench's scenarios, because each one depends on when the bench drives the switch-node and feedback flags. The same holds for PWM reversal during a wait and for restart after disable or undervoltage.

// File: rtl/dtc_pkg.sv
package dtc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_TO_LS  = 3'd1,
    ST_LS     = 3'd2,
    ST_TO_HS  = 3'd3,
    ST_HS_DLY = 3'd4,
    ST_HS     = 3'd5
  } dt_state_e;

  // positions inside the synchronized input vector
  localparam int IX_PWM  = 0;
  localparam int IX_RUN  = 1;
  localparam int IX_UVLO = 2;
  localparam int IX_SWH  = 3;
  localparam int IX_SWL  = 4;
  localparam int IX_GFB  = 5;
  localparam int SYNC_W  = 6;

endpackage

// File: rtl/dtc_sync.sv
module dtc_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stg_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg_q[0] <= '0;
          else        stg_q[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg_q[s] <= '0;
          else        stg_q[s] <= stg_q[s-1];
        end
      end
    end
  endgenerate

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/dtc_timer.sv
module dtc_timer #(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          en_i,
  output logic [CW-1:0] cnt_o
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)                   cnt_d = '0;
    else if (en_i && cnt_q != '1) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/dtc_seq.sv
module dtc_seq
  import dtc_pkg::*;
#(
  parameter int FIXED_DLY = 15,
  parameter int TIMEOUT   = 19,
  parameter int HS_DLY    = 3,
  parameter int CW        = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwm_s,
  input  logic          run_s,
  input  logic          uvlo_s,
  input  logic          sw_hi_s,
  input  logic          sw_lo_s,
  input  logic          gfb_s,
  input  logic [CW-1:0] cnt_i,
  output dt_state_e     state_o,
  output logic          clr_o,
  output logic          cnt_en_o
);

  localparam logic [CW-1:0] FIX_LAST = CW'(FIXED_DLY - 1);
  localparam logic [CW-1:0] TMO_LAST = CW'(TIMEOUT - 1);
  localparam logic [CW-1:0] HSD_LAST = CW'(HS_DLY - 1);

  dt_state_e state_q, state_d;
  logic      seen_q, seen_d;

  // next-state logic
  always_comb begin
    state_d = state_q;
    if (uvlo_s || !run_s) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE:   state_d = pwm_s ? ST_TO_HS : ST_TO_LS;
        ST_TO_LS: begin
          if (pwm_s)                           state_d = ST_TO_HS;
          else if (seen_q && sw_lo_s)          state_d = ST_LS;
          else if (!seen_q && cnt_i >= FIX_LAST) state_d = ST_LS;
          else if (cnt_i >= TMO_LAST)          state_d = ST_LS;
        end
        ST_LS:     if (pwm_s) state_d = ST_TO_HS;
        ST_TO_HS: begin
          if (!pwm_s)     state_d = ST_TO_LS;
          else if (gfb_s) state_d = ST_HS_DLY;
        end
        ST_HS_DLY: begin
          if (!pwm_s)                 state_d = ST_TO_LS;
          else if (cnt_i >= HSD_LAST) state_d = ST_HS;
        end
        ST_HS:     if (!pwm_s) state_d = ST_TO_LS;
        default:   state_d = ST_IDLE;
      endcase
    end
  end

  // switch-node rise memory, cleared on every entry to the low-side wait
  always_comb begin
    seen_d = 1'b0;
    if (state_q == ST_TO_LS) seen_d = seen_q | sw_hi_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      seen_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      seen_q  <= seen_d;
    end
  end

  assign clr_o    = (state_d != state_q);
  assign cnt_en_o = (state_q == ST_TO_LS) || (state_q == ST_HS_DLY);
  assign state_o  = state_q;

endmodule

// File: rtl/gate_seq_ctrl.sv
module gate_seq_ctrl
  import dtc_pkg::*;
#(
  parameter int FIXED_DLY   = 15,
  parameter int TIMEOUT     = 19,
  parameter int HS_DLY      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwm_i,
  input  logic       dis_n_i,
  input  logic       uvlo_i,
  input  logic       sw_hi_i,
  input  logic       sw_lo_i,
  input  logic       gfb_lo_i,
  output logic       hs_en_o,
  output logic       ls_en_o,
  output logic [2:0] state_o
);

  localparam int CW = $clog2(FIXED_DLY + TIMEOUT + HS_DLY + 1);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_core_n = rst_pipe_q[1];

  logic [SYNC_W-1:0] raw_vec;
  logic [SYNC_W-1:0] syn_vec;

  always_comb begin
    raw_vec          = '0;
    raw_vec[IX_PWM]  = pwm_i;
    raw_vec[IX_RUN]  = dis_n_i;
    raw_vec[IX_UVLO] = uvlo_i;
    raw_vec[IX_SWH]  = sw_hi_i;
    raw_vec[IX_SWL]  = sw_lo_i;
    raw_vec[IX_GFB]  = gfb_lo_i;
  end

  dtc_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_core_n),
    .d_i   (raw_vec),
    .q_o   (syn_vec)
  );

  logic [CW-1:0] cnt;
  logic          cnt_clr;
  logic          cnt_en;
  dt_state_e     st;

  dtc_timer #(.CW(CW)) u_tmr (
    .clk   (clk),
    .rst_n (rst_core_n),
    .clr_i (cnt_clr),
    .en_i  (cnt_en),
    .cnt_o (cnt)
  );

  dtc_seq #(
    .FIXED_DLY (FIXED_DLY),
    .TIMEOUT   (TIMEOUT),
    .HS_DLY    (HS_DLY),
    .CW        (CW)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .pwm_s    (syn_vec[IX_PWM]),
    .run_s    (syn_vec[IX_RUN]),
    .uvlo_s   (syn_vec[IX_UVLO]),
    .sw_hi_s  (syn_vec[IX_SWH]),
    .sw_lo_s  (syn_vec[IX_SWL]),
    .gfb_s    (syn_vec[IX_GFB]),
    .cnt_i    (cnt),
    .state_o  (st),
    .clr_o    (cnt_clr),
    .cnt_en_o (cnt_en)
  );

  // raw disable gates the decoded enables with no clock in the path
  assign hs_en_o = (st == ST_HS) & dis_n_i;
  assign ls_en_o = (st == ST_LS) & dis_n_i;
  assign state_o = st;

endmodule

// File: rtl/dtc_checker.sv
module dtc_checker
  import dtc_pkg::*;
#(
  parameter int TIMEOUT = 19
) (
  input logic       clk,
  input logic       rst_n,
  input logic       dis_n_i,
  input logic       uvlo_i,
  input logic       hs_en_o,
  input logic       ls_en_o,
  input logic [2:0] state_o
);

  localparam int WW = $clog2(TIMEOUT + 2) + 1;

  logic [2:0]    since_q;
  logic [WW-1:0] wait_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              since_q <= '0;
    else if (since_q != 3'd7) since_q <= since_q + 3'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      wait_q <= '0;
    else if (state_o != ST_TO_LS)    wait_q <= '0;
    else if (wait_q != '1)           wait_q <= wait_q + 1'b1;
  end

  p_no_overlap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_en_o && ls_en_o));

  p_dis_cuts_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !dis_n_i |-> (!hs_en_o && !ls_en_o));

  p_dis_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (since_q >= 3'd6 && !$past(dis_n_i, 3)) |-> (state_o == ST_IDLE));

  p_ls_from_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ls_en_o) && $past(dis_n_i)) |-> ($past(state_o) == ST_TO_LS));

  p_wait_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wait_q <= WW'(TIMEOUT));

  p_hs_from_delay_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(hs_en_o) && $past(dis_n_i)) |-> ($past(state_o) == ST_HS_DLY));

  p_uvlo_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (since_q >= 3'd6 && $past(uvlo_i, 3)) |->
      (state_o == ST_IDLE && !hs_en_o && !ls_en_o));

endmodule

bind gate_seq_ctrl dtc_checker #(.TIMEOUT(TIMEOUT)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .dis_n_i (dis_n_i),
  .uvlo_i  (uvlo_i),
  .hs_en_o (hs_en_o),
  .ls_en_o (ls_en_o),
  .state_o (state_o)
);

// File: tb/sim_gate_seq_ctrl.sv
`timescale 1ns/1ps
module sim_gate_seq_ctrl;

  localparam int FD  = 15;
  localparam int TO  = 19;
  localparam int HD  = 3;
  localparam int LAT = 3;

  // table: kind 0 fixed, 1 adaptive, 2 timeout; lo_at = cycle sw_lo is driven
  localparam int NV = 5;
  localparam int V_KIND [NV] = '{0, 1, 1, 1, 2};
  localparam int V_LO   [NV] = '{0, 5, 9, 14, 0};
  localparam int V_EXP  [NV] = '{FD, 5 + LAT, 9 + LAT, 14 + LAT, TO};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwm = 1'b0, dis_n = 1'b1, uvlo = 1'b0;
  logic sw_hi = 1'b0, sw_lo = 1'b0, gfb = 1'b1;
  logic hs_en, ls_en;
  logic [2:0] st;

  int n_chk = 0, n_fail = 0, ovl = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  gate_seq_ctrl #(.FIXED_DLY(FD), .TIMEOUT(TO), .HS_DLY(HD)) u0 (
    .clk(clk), .rst_n(rst_n), .pwm_i(pwm), .dis_n_i(dis_n), .uvlo_i(uvlo),
    .sw_hi_i(sw_hi), .sw_lo_i(sw_lo), .gfb_lo_i(gfb),
    .hs_en_o(hs_en), .ls_en_o(ls_en), .state_o(st)
  );

  always @(negedge clk) if (rst_n && hs_en && ls_en) ovl++;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_out(input bit side_hs, input bit lvl, output int n);
    n = -1;
    for (int i = 1; i <= 80; i++) begin
      @(negedge clk);
      if ((side_hs ? hs_en : ls_en) == lvl) begin
        n = i;
        break;
      end
    end
  endtask

  // from low side on (or idle) to high side on, measuring R10 and R7
  task automatic goto_hs();
    int n;
    gfb = 1'b0;
    pwm = 1'b1;
    if (ls_en) begin
      wait_out(1'b0, 1'b0, n);
      check(n == LAT, "R10 pwm rise to low-side off", n, LAT);
    end
    gfb = 1'b1;
    wait_out(1'b1, 1'b1, n);
    check(n == HD + LAT, "R7 feedback to high-side on", n, HD + LAT);
    sw_lo = 1'b0;
    sw_hi = 1'b0;
  endtask

  task automatic finish_run();
    check(ovl == 0, "R2 overlap cycles", ovl, 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int n;
    bit bad, seen;
    repeat (3) @(negedge clk);
    check(st == 3'd0, "R11 reset state", st, 0);
    check(!hs_en && !ls_en, "R11 reset enables", {hs_en, ls_en}, 0);
    rst_n = 1'b1;
    repeat (30) @(negedge clk);
    check(ls_en && !hs_en, "R1 startup low side on", {hs_en, ls_en}, 1);
    check(st == 3'd2, "R11 low-side state code", st, 2);

    // table of low-side handover paths
    for (int i = 0; i < NV; i++) begin
      int got;
      goto_hs();
      pwm = 1'b0;
      wait_out(1'b1, 1'b0, n);
      check(n == LAT, "R10 pwm fall to high-side off", n, LAT);
      if (V_KIND[i] != 0) sw_hi = 1'b1;
      got = -1;
      bad = 1'b0;
      for (int k = 1; k <= 60; k++) begin
        @(negedge clk);
        if (ls_en) begin got = k; break; end
        if (hs_en) bad = 1'b1;
        if (V_KIND[i] == 1 && k == V_LO[i]) begin
          sw_hi = 1'b0;
          sw_lo = 1'b1;
        end
      end
      check(!bad, "R2 high side stayed off in wait", bad, 0);
      case (V_KIND[i])
        0:       check(got == V_EXP[i], "R5 fixed fallback delay", got, V_EXP[i]);
        1:       check(got == V_EXP[i], "R4 adaptive low-side delay", got, V_EXP[i]);
        default: check(got == V_EXP[i], "R6 timeout delay", got, V_EXP[i]);
      endcase
      sw_hi = 1'b0;
      sw_lo = 1'b1;
    end

    // R1 steady states
    check(ls_en && !hs_en && st == 3'd2, "R1 pwm low steady", {hs_en, ls_en}, 1);
    goto_hs();
    check(hs_en && !ls_en && st == 3'd5, "R1 pwm high steady", {hs_en, ls_en}, 2);

    // R3 disable during high side
    @(negedge clk);
    dis_n = 1'b0;
    #1;
    check(!hs_en && !ls_en, "R3 immediate cut", {hs_en, ls_en}, 0);
    repeat (4) @(negedge clk);
    check(st == 3'd0, "R3 idle while disabled", st, 0);
    dis_n = 1'b1;
    wait_out(1'b1, 1'b1, n);
    check(n == HD + LAT + 1, "R3 restart after disable", n, HD + LAT + 1);

    // R8 undervoltage during low side
    pwm = 1'b0;
    wait_out(1'b0, 1'b1, n);
    check(n == LAT + FD, "R5 fixed path from pwm fall", n, LAT + FD);
    uvlo = 1'b1;
    wait_out(1'b0, 1'b0, n);
    check(n == LAT, "R8 enables fall", n, LAT);
    repeat (2) @(negedge clk);
    check(st == 3'd0, "R8 idle in lockout", st, 0);
    pwm = 1'b1;
    bad = 1'b0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (hs_en || ls_en) bad = 1'b1;
    end
    check(!bad, "R8 pwm ignored in lockout", bad, 0);
    uvlo = 1'b0;
    wait_out(1'b1, 1'b1, n);
    check(n == HD + LAT + 1, "R8 restart after lockout", n, HD + LAT + 1);

    // R3 disable during low side
    pwm = 1'b0;
    wait_out(1'b0, 1'b1, n);
    @(negedge clk);
    dis_n = 1'b0;
    #1;
    check(!ls_en && !hs_en, "R3 immediate cut low side", {hs_en, ls_en}, 0);
    repeat (4) @(negedge clk);
    dis_n = 1'b1;
    wait_out(1'b0, 1'b1, n);
    check(n == LAT + FD, "R3 low side restart", n, LAT + FD);

    // R9 reversal during low-side wait
    goto_hs();
    pwm = 1'b0;
    wait_out(1'b1, 1'b0, n);
    repeat (2) @(negedge clk);
    pwm = 1'b1;
    bad = 1'b0;
    n = -1;
    for (int k = 1; k <= 40; k++) begin
      @(negedge clk);
      if (ls_en) bad = 1'b1;
      if (hs_en && n < 0) n = k;
    end
    check(!bad, "R9 low side never on", bad, 0);
    check(n == HD + LAT + 1, "R9 high side resumes", n, HD + LAT + 1);

    // R9 and R7: reversal while waiting for gate feedback
    pwm = 1'b0;
    wait_out(1'b0, 1'b1, n);
    gfb = 1'b0;
    pwm = 1'b1;
    wait_out(1'b0, 1'b0, n);
    seen = 1'b0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (hs_en) seen = 1'b1;
    end
    check(!seen, "R7 high side held without feedback", seen, 0);
    check(st == 3'd3, "R11 feedback wait code", st, 3);
    pwm = 1'b0;
    wait_out(1'b0, 1'b1, n);
    check(n == LAT + FD, "R9 low side after reversal", n, LAT + FD);

    finish_run();
  end

endmodule